// File: doc/BRIEF.md
# Instruction Word Decoder with Four-Phase Cycle Sequencer

This block sits between program memory and the execution datapath of a small 8-bit core with 14-bit instruction words. It paces execution with a four-phase instruction cycle, in which every phase lasts one input clock. At the clock edge that closes the fourth phase, it captures the word offered on the program-memory port.

For the whole of the following cycle, it presents that word split into a format class and the operand fields that class defines. The fields are the opcode bits, the result-destination select, the bit number, the register-file address, and an 8-bit or 11-bit constant. Fields that the class does not use read as zero.

The execution side may report that the current instruction took a skip or changed the program counter. When it does, the word captured at the end of that cycle is discarded and replaced by an all-zero slot with both write enables low. The instruction therefore occupies a second cycle that does nothing.

Top module: `instr_decode_seq`

## Requirements
- R1: After reset `phase_stb` is 4'b0001 (first phase). On every clock it rotates one place left (0001, 0010, 0100, 1000, 0001) and is always exactly one-hot.
- R2: `prog_word` is captured only at the clock edge that ends the fourth phase. The decoded outputs change only at that edge and hold for the next four clocks. `instr_valid` is high for exactly the first-phase clock after each capture, and it stays low until the first capture after reset.
- R3: `fmt_class` is taken from word bits 13:12: 0 means register-byte, 1 means bit-on-register, 2 means long jump/call with an 11-bit constant, and 3 means short constant or control.
- R4: In class 0, `op_bits` is bits 13:8, `dest_sel` is bit 7, and `reg_addr` is bits 6:0. A `dest_sel` of 0 raises `wr_w_en` (result to the working register), and a `dest_sel` of 1 raises `wr_f_en` (result to the addressed register). The two write enables are never high together.
- R5: In class 1, `op_bits` is {bits 13:10, 2'b00}, `bit_num` is bits 9:7, and `reg_addr` is bits 6:0. `wr_f_en` is 1 and `wr_w_en` is 0.
- R6: In class 3, `op_bits` is bits 13:8 and `lit8` is bits 7:0. `wr_w_en` is 1 and `wr_f_en` is 0.
- R7: In class 2, `op_bits` is {bits 13:11, 3'b000} and `lit11` is bits 10:0. Both write enables are 0.
- R8: Any field the current class does not define (`dest_sel`, `bit_num`, `reg_addr`, `lit8`, `lit11`) reads 0, whatever the word bits are.
- R9: If `flush_req` is high on any clock of a cycle, the word captured at the end of that cycle is replaced by zero. In that case all fields are 0, the class is 0, and both write enables are 0, while `instr_valid` still pulses. The request affects only that one capture.
- R10: While `rst_n` is low, the decoded outputs are all zero, both write enables are 0, and `instr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_word | input | 14 | Instruction word from program memory |
| flush_req | input | 1 | Taken skip or program-counter change reported by execution |
| fmt_class | output | 2 | Format class of the held word |
| op_bits | output | 6 | Opcode bits, left-aligned, unused low bits zero |
| dest_sel | output | 1 | Result destination (0 working register, 1 file register) |
| bit_num | output | 3 | Bit number for bit-on-register words |
| reg_addr | output | 7 | Register-file address |
| lit8 | output | 8 | Short constant |
| lit11 | output | 11 | Long jump/call constant |
| wr_w_en | output | 1 | Working-register write enable |
| wr_f_en | output | 1 | File-register write enable |
| phase_stb | output | 4 | One-hot phase strobe |
| instr_valid | output | 1 | One-clock pulse at the start of each decoded cycle |

## Verification
A phase counter that slips shows up within one clock, because `phase_stb` leaves its rotation and `instr_valid` lands outside the first phase. A capture made at the wrong phase shows up within four clocks, when the fields change in mid-cycle or reflect a word that was present only in the middle phases. A flush flag that is lost or that sticks appears at the next first phase: either a non-zero slot follows a flush, or a zero slot follows an ordinary cycle, which can be told apart from a genuine all-zero word by its write enables.

// File: rtl/instr_decode_seq.sv
module instr_decode_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] prog_word,
  input  logic        flush_req,
  output logic [1:0]  fmt_class,
  output logic [5:0]  op_bits,
  output logic        dest_sel,
  output logic [2:0]  bit_num,
  output logic [6:0]  reg_addr,
  output logic [7:0]  lit8,
  output logic [10:0] lit11,
  output logic        wr_w_en,
  output logic        wr_f_en,
  output logic [3:0]  phase_stb,
  output logic        instr_valid
);

  localparam logic [1:0] CL_BYTE = 2'd0;
  localparam logic [1:0] CL_BIT  = 2'd1;
  localparam logic [1:0] CL_JUMP = 2'd2;
  localparam logic [1:0] CL_LIT  = 2'd3;
  localparam logic [1:0] PH_LAST = 2'd3;

  logic [1:0]  phase;
  logic [13:0] ir;
  logic        ir_flush;
  logic        flush_pend;
  logic        loaded;
  logic        kill;

  assign kill = flush_pend | flush_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      ir         <= '0;
      ir_flush   <= 1'b0;
      flush_pend <= 1'b0;
      loaded     <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      if (phase == PH_LAST) begin
        ir         <= kill ? '0 : prog_word;
        ir_flush   <= kill;
        flush_pend <= 1'b0;
        loaded     <= 1'b1;
      end else if (flush_req) begin
        flush_pend <= 1'b1;
      end
    end
  end

  assign phase_stb   = 4'b0001 << phase;
  assign instr_valid = loaded && (phase == 2'd0);
  assign fmt_class   = ir[13:12];

  always_comb begin
    op_bits  = '0;
    dest_sel = 1'b0;
    bit_num  = '0;
    reg_addr = '0;
    lit8     = '0;
    lit11    = '0;
    wr_w_en  = 1'b0;
    wr_f_en  = 1'b0;
    case (fmt_class)
      CL_BYTE: begin
        op_bits  = ir[13:8];
        dest_sel = ir[7];
        reg_addr = ir[6:0];
        wr_w_en  = ~ir[7];
        wr_f_en  = ir[7];
      end
      CL_BIT: begin
        op_bits  = {ir[13:10], 2'b00};
        bit_num  = ir[9:7];
        reg_addr = ir[6:0];
        wr_f_en  = 1'b1;
      end
      CL_JUMP: begin
        op_bits = {ir[13:11], 3'b000};
        lit11   = ir[10:0];
      end
      CL_LIT: begin
        op_bits = ir[13:8];
        lit8    = ir[7:0];
        wr_w_en = 1'b1;
      end
      default: ;
    endcase
    if (ir_flush || !loaded) begin
      wr_w_en = 1'b0;
      wr_f_en = 1'b0;
    end
  end

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_stb[3] |=> phase_stb[0]);
  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_stb[0] |=> phase_stb[1]);
  // R2
  valid_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> phase_stb[0]);
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);
  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_stb[3] |=> $stable(ir));
  // R4
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_w_en && wr_f_en));
  // R7
  jump_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_class == CL_JUMP) |-> (!wr_w_en && !wr_f_en));
  // R9
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_flush |-> (ir == '0 && !wr_w_en && !wr_f_en));

endmodule

// File: tb/sim_instr_decode_seq.sv
module sim_instr_decode_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] prog_word;
  logic        flush_req;
  logic [1:0]  fmt_class;
  logic [5:0]  op_bits;
  logic        dest_sel;
  logic [2:0]  bit_num;
  logic [6:0]  reg_addr;
  logic [7:0]  lit8;
  logic [10:0] lit11;
  logic        wr_w_en, wr_f_en;
  logic [3:0]  phase_stb;
  logic        instr_valid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  instr_decode_seq u0 (
    .clk(clk), .rst_n(rst_n), .prog_word(prog_word), .flush_req(flush_req),
    .fmt_class(fmt_class), .op_bits(op_bits), .dest_sel(dest_sel),
    .bit_num(bit_num), .reg_addr(reg_addr), .lit8(lit8), .lit11(lit11),
    .wr_w_en(wr_w_en), .wr_f_en(wr_f_en), .phase_stb(phase_stb),
    .instr_valid(instr_valid)
  );

  // {word, flush, class, op, dest, bit, addr, lit8, lit11, ww, wf}
  localparam logic [54:0] VEC [0:10] = '{
    {14'h0785, 1'b0, 2'd0, 6'h07, 1'b1, 3'd0, 7'h05, 8'h00, 11'h000, 1'b0, 1'b1},
    {14'h0A23, 1'b0, 2'd0, 6'h0A, 1'b0, 3'd0, 7'h23, 8'h00, 11'h000, 1'b1, 1'b0},
    {14'h15C5, 1'b0, 2'd1, 6'h14, 1'b0, 3'd3, 7'h45, 8'h00, 11'h000, 1'b0, 1'b1},
    {14'h1FFF, 1'b0, 2'd1, 6'h1C, 1'b0, 3'd7, 7'h7F, 8'h00, 11'h000, 1'b0, 1'b1},
    {14'h30A5, 1'b0, 2'd3, 6'h30, 1'b0, 3'd0, 7'h00, 8'hA5, 11'h000, 1'b1, 1'b0},
    {14'h3EFF, 1'b0, 2'd3, 6'h3E, 1'b0, 3'd0, 7'h00, 8'hFF, 11'h000, 1'b1, 1'b0},
    {14'h25A3, 1'b0, 2'd2, 6'h20, 1'b0, 3'd0, 7'h00, 8'h00, 11'h5A3, 1'b0, 1'b0},
    {14'h2FFF, 1'b0, 2'd2, 6'h28, 1'b0, 3'd0, 7'h00, 8'h00, 11'h7FF, 1'b0, 1'b0},
    {14'h1FFF, 1'b1, 2'd0, 6'h00, 1'b0, 3'd0, 7'h00, 8'h00, 11'h000, 1'b0, 1'b0},
    {14'h0000, 1'b0, 2'd0, 6'h00, 1'b0, 3'd0, 7'h00, 8'h00, 11'h000, 1'b1, 1'b0},
    {14'h0785, 1'b0, 2'd0, 6'h07, 1'b1, 3'd0, 7'h05, 8'h00, 11'h000, 1'b0, 1'b1}
  };

  function automatic logic [39:0] obs();
    return {fmt_class, op_bits, dest_sel, bit_num, reg_addr, lit8, lit11, wr_w_en, wr_f_en};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [54:0] v);
    if (v[40]) return "R9 flushed slot";
    case (v[39:38])
      2'd0: return "R3 R4 R8 byte class";
      2'd1: return "R3 R5 R8 bit class";
      2'd2: return "R3 R7 R8 jump class";
      default: return "R3 R6 R8 literal class";
    endcase
  endfunction

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_word = 14'h0785; flush_req = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 outputs in reset", {24'd0, obs()}, 64'd0);
    chk("R10 valid in reset", {63'd0, instr_valid}, 64'd0);
    rst_n = 1'b1;
    // R1 phase rotation from Q1
    chk("R1 phase after reset", {60'd0, phase_stb}, 64'h1);
    @(negedge clk); chk("R1 phase 2", {60'd0, phase_stb}, 64'h2);
    chk("R2 no valid before capture", {63'd0, instr_valid}, 64'd0);
    @(negedge clk); chk("R1 phase 3", {60'd0, phase_stb}, 64'h4);
    @(negedge clk); chk("R1 phase 4", {60'd0, phase_stb}, 64'h8);
    @(negedge clk); chk("R1 phase wrap", {60'd0, phase_stb}, 64'h1);
    chk("R2 valid after capture", {63'd0, instr_valid}, 64'd1);
    @(negedge clk); chk("R2 valid single clock", {63'd0, instr_valid}, 64'd0);
    repeat (3) @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      prog_word = VEC[i][54:41];
      flush_req = 1'b0;
      @(negedge clk);
      flush_req = VEC[i][40];
      @(negedge clk);
      flush_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(tag_of(VEC[i]), {24'd0, obs()}, {24'd0, VEC[i][39:0]});
      chk("R2 valid per cycle", {63'd0, instr_valid}, 64'd1);
    end

    // R9 flush raised only in the last phase
    prog_word = 14'h30A5;
    repeat (3) @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    chk("R9 flush in phase 4", {24'd0, obs()}, 64'd0);
    chk("R9 valid on flushed slot", {63'd0, instr_valid}, 64'd1);

    // R2 mid-cycle word changes ignored; outputs hold
    prog_word = 14'h25A3;
    @(negedge clk);
    chk("R2 hold in phase 2", {24'd0, obs()}, 64'd0);
    prog_word = 14'h3EFF;
    @(negedge clk);
    chk("R2 hold in phase 3", {24'd0, obs()}, 64'd0);
    prog_word = 14'h25A3;
    repeat (2) @(negedge clk);
    chk("R2 R7 capture at end of phase 4",
        {24'd0, obs()}, {24'd0, 2'd2, 6'h20, 1'b0, 3'd0, 7'h00, 8'h00, 11'h5A3, 1'b0, 1'b0});

    // R9 flush raised only in the first phase, then not sticky
    prog_word = 14'h15C5;
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 flush in phase 1", {24'd0, obs()}, 64'd0);
    repeat (4) @(negedge clk);
    chk("R9 flush not sticky R5",
        {24'd0, obs()}, {24'd0, 2'd1, 6'h14, 1'b0, 3'd3, 7'h45, 8'h00, 11'h000, 1'b0, 1'b1});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule